// File: doc/BRIEF.md
# Half-Precision to Single-Precision Widening Converter

This block takes a 16-bit binary16 bit pattern and produces the 32-bit binary32 pattern that encodes exactly the same value. Every binary16 value is representable in binary32, so the conversion never rounds and raises no exception. Normal inputs only need their exponent re-biased. Infinities and NaNs keep their sign and their 10-bit payload. Signed zeros stay signed zeros. Subnormal inputs become normal single-precision values. For these, a leading-one priority encoder finds the top set bit of the fraction, moves it into the hidden-bit position, and sets the exponent from its position.

The block has one register stage. A word presented with `in_valid` high appears on `out_single` one clock later, together with `out_valid`. When `in_valid` is low, the output register keeps its previous contents.

Top module: `half_to_single`

## Requirements
- R1: The output sign bit 31 equals input bit 15 of the word that was accepted.
- R2: An input whose bits [14:0] are all zero produces an output whose bits [30:0] are all zero.
- R3: An input with exponent field [14:10] zero and a nonzero fraction produces a normal output. If p is the position of the highest set fraction bit (0..9), the output exponent is 103+p. The output fraction is the input fraction shifted left by 10−p, truncated to 10 bits and placed in bits [22:13].
- R4: An input with exponent field [14:10] equal to 31 produces output exponent [30:23] = 255, with the input fraction [9:0] copied into bits [22:13].
- R5: An input with an exponent field from 1 to 30 produces output exponent = field + 112, with the fraction copied into bits [22:13].
- R6: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `out_single` holds its value.
- R7: While reset is asserted (`rst_n` low), `out_valid` is 0 and `out_single` is 0.
- R8: Output bits [12:0] are always zero. Converting any non-NaN output back to binary16 returns the original input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_half | input | 16 | binary16 bit pattern |
| out_valid | output | 1 | Output word strobe |
| out_single | output | 32 | binary32 bit pattern |

## Verification
Both formats are fixed, so the converter has no width parameters and the bench builds it in its only configuration. That configuration has just 65,536 possible inputs, so the bench applies every one of them. This covers every leading-one position of the subnormal encoder, both signed zeros, all infinities and all NaN payloads. The bench also narrows each non-NaN result back to binary16 and compares it with the input word.

// File: rtl/half_to_single.sv
module half_to_single (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  output logic        out_valid,
  output logic [31:0] out_single
);
  localparam logic [7:0] EXP_ADJ   = 8'd112;
  localparam logic [7:0] SUB_BASE  = 8'd103;
  localparam logic [4:0] HEXP_ONES = 5'h1f;

  logic       sgn;
  logic [4:0] hexp;
  logic [9:0] hfrac;
  assign sgn   = in_half[15];
  assign hexp  = in_half[14:10];
  assign hfrac = in_half[9:0];

  logic [3:0] lead_pos;
  always_comb begin
    lead_pos = 4'd0;
    for (int i = 0; i < 10; i++)
      if (hfrac[i]) lead_pos = i[3:0];
  end

  logic [3:0]  sh_amt;
  logic [10:0] shifted;
  assign sh_amt  = 4'd10 - lead_pos;
  assign shifted = {1'b0, hfrac} << sh_amt;

  logic [31:0] result;
  always_comb begin
    if (hexp == HEXP_ONES)
      result = {sgn, 8'hff, hfrac, 13'd0};
    else if (hexp != 5'd0)
      result = {sgn, {3'd0, hexp} + EXP_ADJ, hfrac, 13'd0};
    else if (hfrac == 10'd0)
      result = {sgn, 31'd0};
    else
      result = {sgn, SUB_BASE + {4'd0, lead_pos}, shifted[9:0], 13'd0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_single <= 32'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_single <= result;
    end
  end

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_single[31] == $past(in_half[15]));
  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_half[14:0]) == 15'd0) |-> out_single[30:0] == 31'd0);
  p_subnorm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_half[14:10]) == 5'd0 && $past(in_half[9:0]) != 10'd0)
      |-> (out_single[30:23] >= 8'd103 && out_single[30:23] <= 8'd112));
  p_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_half[14:10]) == 5'h1f)
      |-> (out_single[30:23] == 8'hff && out_single[22:13] == $past(in_half[9:0])));
  p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(out_single));
  p_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_single[12:0] == 13'd0);
endmodule

// File: tb/sim_half_to_single.sv
`timescale 1ns/1ps
module sim_half_to_single;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = 16'd0;
  logic        out_valid;
  logic [31:0] out_single;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  half_to_single u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_single(out_single)
  );

  function automatic logic [31:0] model(input logic [15:0] h);
    int e, m;
    logic [31:0] r;
    r = {h[15], 31'd0};
    if (h[14:10] == 5'h1f) begin
      r[30:23] = 8'hff;
      r[22:13] = h[9:0];
    end else if (h[14:0] != 15'd0) begin
      if (h[14:10] != 5'd0) begin
        m = 1024 + int'(h[9:0]);
        e = int'(h[14:10]) - 25;
      end else begin
        m = int'(h[9:0]);
        e = -24;
      end
      while (m < 1024) begin
        m = m * 2;
        e = e - 1;
      end
      r[30:23] = 8'(e + 137);
      r[22:13] = 10'(m - 1024);
    end
    return r;
  endfunction

  function automatic logic [15:0] narrow(input logic [31:0] f);
    int u, sh, m;
    logic [15:0] h;
    h = {f[31], 15'd0};
    if (f[30:23] == 8'hff) h[14:10] = 5'h1f;
    else if (f[30:23] != 8'd0) begin
      u = int'(f[30:23]) - 127;
      if (u >= -14) begin
        h[14:10] = 5'(u + 15);
        h[9:0]   = f[22:13];
      end else begin
        sh = -14 - u;
        m  = 1024 + int'(f[22:13]);
        h[9:0] = 10'(m >> sh);
      end
    end
    return h;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: in=%h actual=%h expected=%h", req, in_half, act, exp);
    end
  endtask

  function automatic string req_of(input logic [15:0] h);
    if (h[14:10] == 5'h1f) return "R4";
    if (h[14:0] == 15'd0) return "R2";
    if (h[14:10] == 5'd0) return "R3";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R7 valid", {31'd0, out_valid}, 32'd0);
    check("R7 data", out_single, 32'd0);
    rst_n = 1'b1;
    for (int v = 0; v < 65536; v++) begin
      in_valid = 1'b1;
      in_half  = 16'(v);
      @(negedge clk);
      check("R6 valid", {31'd0, out_valid}, 32'd1);
      check(req_of(in_half), out_single, model(in_half));
      check("R1 sign", {31'd0, out_single[31]}, {31'd0, in_half[15]});
      check("R8 low", {19'd0, out_single[12:0]}, 32'd0);
      if (!(in_half[14:10] == 5'h1f && in_half[9:0] != 10'd0))
        check("R8 roundtrip", {16'd0, narrow(out_single)}, {16'd0, in_half});
    end
    in_valid = 1'b0;
    in_half  = 16'h1234;
    @(negedge clk);
    check("R6 drop", {31'd0, out_valid}, 32'd0);
    check("R6 hold", out_single, model(16'hffff));
    in_half = 16'h0001;
    @(negedge clk);
    check("R6 hold2", out_single, model(16'hffff));
    in_valid = 1'b1;
    @(negedge clk);
    check("R3 min", out_single, 32'h33800000);
    in_half = 16'h3c00;
    @(negedge clk);
    check("R5 one", out_single, 32'h3f800000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule